// File: doc/BRIEF.md
# Flash Command Unlock Sequencer

This block sits at the command input of a flash memory and guards every operation that can change the array. It watches the bus write cycles presented to it, one per strobe, and tracks them against the two unlock sequences the device accepts. A program needs three command cycles and then a target cycle. An erase needs six cycles. The last of the six names a sector, a block or the whole chip. A one-cycle request strobe goes to the array controller only when a complete, correct sequence has been seen. The strobe carries the target address, the data word and the erase kind.

A cycle that breaks a sequence drops the block back to read mode, and a sequence must then start again from its first cycle. A write-protect pin covers the top 8K words of the address space. While that pin is low, no request is issued that would touch those words. The pin's level is taken when a sequence starts and held until the sequence ends. The active-low reset pin clears any sequence in progress at once. Its release is synchronised to the clock.

Top module: `sdp_cmd_seq`

## Requirements
- R1: After the cycles (5555h, AAh), (2AAAh, 55h), (5555h, A0h), the next accepted write is the program target. One cycle after that write's strobe, `prog_req` is 1, `op_addr` holds its address and `op_data` holds its full 16-bit data word. Command addresses are compared on address bits 15..0.
- R2: After (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), a sixth write issues an erase one cycle later. The sixth write is data 30h at any address for a sector, 50h at any address for a block, or 10h at 5555h for the chip. `erase_req` is 1, `erase_kind` is 0 for sector, 1 for block and 2 for chip, and `op_addr` holds the sixth cycle's address.
- R3: An accepted write whose address or data does not fit the expected next cycle ends the sequence. No request is issued, and the following write is treated as the first cycle of a new sequence.
- R4: Data bits 15..8 have no effect on command cycles. Only bits 7..0 are compared.
- R5: A strobe is ignored, with the sequence position unchanged, when `oe_n` is 0, `ce_n` is 1 or `we_n` is 1.
- R6: When the latched write-protect level is 0, a request is suppressed if it would touch words F_E000h..F_FFFFh. This covers a program to those words, a sector (2K words) or block (32K words) containing them, and any chip erase. The sequence still returns to read mode.
- R7: `wp_n` is latched on the first cycle (5555h, AAh) of a sequence. Changes to `wp_n` later in that sequence do not alter the protection decision.
- R8: While `rst_n` is 0, the block holds read mode and issues no request. A sequence interrupted by reset is discarded, and a target write after release issues nothing.
- R9: `read_mode` is 1 exactly when no sequence is in progress: after reset, after any request and after any abort. It is 0 between the first cycle and the last cycle of a sequence.
- R10: `prog_req` and `erase_req` are never 1 together, and each stays high for a single clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_stb | input | 1 | One-cycle strobe marking a bus write |
| ce_n | input | 1 | Chip enable, active low, sampled with the strobe |
| we_n | input | 1 | Write enable, active low, sampled with the strobe |
| oe_n | input | 1 | Output enable, active low, sampled with the strobe |
| addr | input | 20 | Word address of the bus write |
| data | input | 16 | Data word of the bus write |
| wp_n | input | 1 | Write-protect level, low protects the top block |
| prog_req | output | 1 | Program request pulse |
| erase_req | output | 1 | Erase request pulse |
| erase_kind | output | 2 | 0 sector, 1 block, 2 chip |
| op_addr | output | 20 | Target address of the request |
| op_data | output | 16 | Program data word |
| read_mode | output | 1 | High when no sequence is in progress |

## Verification
The bench builds the block with its default parameters: a 20-bit address, a protected range of the top 8K words, 2K-word sectors and 32K-word blocks. These sizes place a sector at FD800h just below the protected range and a sector at FE800h inside it. They also make the block at F8000h overlap the range even though its base lies outside it. This lets the overlap test be checked at both edges and for every erase span. The bench also drives addresses whose bits above bit 15 are set and data words whose upper byte is not zero. These show that only the low address bits and the low data byte take part in command matching.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_U1,
    ST_U2,
    ST_PTGT,
    ST_E3,
    ST_E4,
    ST_E5
  } seq_st_t;

  typedef enum logic [1:0] {
    ER_SECTOR = 2'd0,
    ER_BLOCK  = 2'd1,
    ER_CHIP   = 2'd2
  } er_kind_t;

  typedef enum logic [1:0] {
    SP_WORD,
    SP_SECTOR,
    SP_BLOCK,
    SP_CHIP
  } span_t;

  localparam logic [7:0] CB_KEY1   = 8'hAA;
  localparam logic [7:0] CB_KEY2   = 8'h55;
  localparam logic [7:0] CB_PROG   = 8'hA0;
  localparam logic [7:0] CB_ERPRE  = 8'h80;
  localparam logic [7:0] CB_ESECT  = 8'h30;
  localparam logic [7:0] CB_EBLK   = 8'h50;
  localparam logic [7:0] CB_ECHIP  = 8'h10;

  localparam logic [15:0] KEY_ADDR1 = 16'h5555;
  localparam logic [15:0] KEY_ADDR2 = 16'h2AAA;

endpackage

// File: rtl/sdp_rst_sync.sv
module sdp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_s = s2_q;

endmodule

// File: rtl/sdp_bus_qual.sv
module sdp_bus_qual #(
  parameter int unsigned CMD_AW = 16
) (
  input  logic              wr_stb,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        data_lo,
  output logic              wr_ok,
  output logic              at_k1,
  output logic              at_k2,
  output logic [7:0]        cbyte
);
  import sdp_pkg::*;

  localparam logic [CMD_AW-1:0] K1 = CMD_AW'(KEY_ADDR1);
  localparam logic [CMD_AW-1:0] K2 = CMD_AW'(KEY_ADDR2);

  // A write only counts when the strobe meets a selected, write-enabled,
  // output-disabled bus.
  always_comb begin
    wr_ok = wr_stb && !ce_n && !we_n && oe_n;
    at_k1 = (addr_lo == K1);
    at_k2 = (addr_lo == K2);
    cbyte = data_lo;
  end

endmodule

// File: rtl/sdp_prot_chk.sv
module sdp_prot_chk
  import sdp_pkg::*;
#(
  parameter int unsigned AW         = 20,
  parameter int unsigned PROT_WORDS = 8192,
  parameter int unsigned PROT_BASE  = (1 << AW) - PROT_WORDS,
  parameter int unsigned SEC_WORDS  = 2048,
  parameter int unsigned BLK_WORDS  = 32768
) (
  input  logic [AW-1:0] addr,
  input  span_t         span,
  input  logic          wp_lat,
  output logic          hit
);

  localparam int unsigned WW = AW + 1;
  localparam logic [WW-1:0] P_LO = WW'(PROT_BASE);
  localparam logic [WW-1:0] P_HI = WW'(PROT_BASE) + WW'(PROT_WORDS);

  logic [WW-1:0] size_w;
  logic [WW-1:0] base_w;
  logic [WW-1:0] end_w;

  always_comb begin
    unique case (span)
      SP_WORD:   size_w = WW'(1);
      SP_SECTOR: size_w = WW'(SEC_WORDS);
      SP_BLOCK:  size_w = WW'(BLK_WORDS);
      default:   size_w = WW'(1) << AW;
    endcase
    base_w = {1'b0, addr} & ~(size_w - WW'(1));
    end_w  = base_w + size_w;
    hit    = !wp_lat && (base_w < P_HI) && (end_w > P_LO);
  end

endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm
  import sdp_pkg::*;
#(
  parameter int unsigned AW = 20,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_s,
  input  logic          wr_ok,
  input  logic          at_k1,
  input  logic          at_k2,
  input  logic [7:0]    cbyte,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          wp_n,
  input  logic          prot_hit,
  output span_t         span,
  output logic          wp_lat,
  output logic          prog_req,
  output logic          erase_req,
  output logic [1:0]    erase_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          read_mode
);

  seq_st_t       st_q, st_d;
  logic          wp_q, wp_d;
  logic          cand_prog, cand_er;
  logic          fire_prog, fire_er;
  er_kind_t      kind_c;
  logic          prog_q, erase_q;
  logic [1:0]    kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  // Next-state logic
  always_comb begin
    st_d      = st_q;
    wp_d      = wp_q;
    cand_prog = 1'b0;
    cand_er   = 1'b0;
    kind_c    = ER_SECTOR;
    span      = SP_WORD;
    if (wr_ok) begin
      unique case (st_q)
        ST_IDLE: begin
          if (at_k1 && cbyte == CB_KEY1) begin
            st_d = ST_U1;
            wp_d = wp_n;
          end
        end
        ST_U1: st_d = (at_k2 && cbyte == CB_KEY2) ? ST_U2 : ST_IDLE;
        ST_U2: begin
          if (at_k1 && cbyte == CB_PROG)       st_d = ST_PTGT;
          else if (at_k1 && cbyte == CB_ERPRE) st_d = ST_E3;
          else                                 st_d = ST_IDLE;
        end
        ST_PTGT: begin
          st_d      = ST_IDLE;
          cand_prog = 1'b1;
          span      = SP_WORD;
        end
        ST_E3: st_d = (at_k1 && cbyte == CB_KEY1) ? ST_E4 : ST_IDLE;
        ST_E4: st_d = (at_k2 && cbyte == CB_KEY2) ? ST_E5 : ST_IDLE;
        ST_E5: begin
          st_d = ST_IDLE;
          if (cbyte == CB_ESECT) begin
            cand_er = 1'b1;
            kind_c  = ER_SECTOR;
            span    = SP_SECTOR;
          end else if (cbyte == CB_EBLK) begin
            cand_er = 1'b1;
            kind_c  = ER_BLOCK;
            span    = SP_BLOCK;
          end else if (cbyte == CB_ECHIP && at_k1) begin
            cand_er = 1'b1;
            kind_c  = ER_CHIP;
            span    = SP_CHIP;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
    fire_prog = cand_prog && !prot_hit;
    fire_er   = cand_er && !prot_hit;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      wp_q    <= 1'b0;
      prog_q  <= 1'b0;
      erase_q <= 1'b0;
      kind_q  <= 2'd0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      wp_q    <= wp_d;
      prog_q  <= fire_prog;
      erase_q <= fire_er;
      if (fire_prog || fire_er) begin
        kind_q <= kind_c;
        addr_q <= addr;
        data_q <= data;
      end
    end
  end

  assign wp_lat     = wp_q;
  assign prog_req   = prog_q;
  assign erase_req  = erase_q;
  assign erase_kind = kind_q;
  assign op_addr    = addr_q;
  assign op_data    = data_q;
  assign read_mode  = (st_q == ST_IDLE);

  // R5: a disqualified strobe leaves the sequence position alone
  a_r5_inhibit_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !wr_ok |=> $stable(st_q));

  // R1: a program request only follows the target-wait position
  a_r1_prog_src: assert property (@(posedge clk) disable iff (!rst_s)
    prog_q |-> $past(st_q) == ST_PTGT);

  // R2: an erase request only follows the final erase position
  a_r2_erase_src: assert property (@(posedge clk) disable iff (!rst_s)
    erase_q |-> $past(st_q) == ST_E5);

  // R3: a wrong second cycle returns to read mode
  a_r3_abort_u1: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_U1 && wr_ok && !at_k2) |=> st_q == ST_IDLE);

  // R10: requests are exclusive and single-cycle
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_s)
    !(prog_q && erase_q));

  a_r10_prog_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    prog_q |=> !prog_q);

  a_r10_erase_pulse: assert property (@(posedge clk) disable iff (!rst_s)
    erase_q |=> !erase_q);

  // R9: any request leaves the block in read mode
  a_r9_idle_after_req: assert property (@(posedge clk) disable iff (!rst_s)
    (prog_q || erase_q) |-> st_q == ST_IDLE);

endmodule

// File: rtl/sdp_cmd_seq.sv
module sdp_cmd_seq #(
  parameter int unsigned AW         = 20,
  parameter int unsigned DW         = 16,
  parameter int unsigned CMD_AW     = 16,
  parameter int unsigned PROT_WORDS = 8192,
  parameter int unsigned SEC_WORDS  = 2048,
  parameter int unsigned BLK_WORDS  = 32768
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_stb,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          wp_n,
  output logic          prog_req,
  output logic          erase_req,
  output logic [1:0]    erase_kind,
  output logic [AW-1:0] op_addr,
  output logic [DW-1:0] op_data,
  output logic          read_mode
);
  import sdp_pkg::*;

  localparam int unsigned PROT_BASE = (1 << AW) - PROT_WORDS;

  logic       rst_s;
  logic       wr_ok;
  logic       at_k1;
  logic       at_k2;
  logic [7:0] cbyte;
  span_t      span;
  logic       wp_lat;
  logic       prot_hit;

  sdp_rst_sync u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  sdp_bus_qual #(.CMD_AW(CMD_AW)) u_qual (
    .wr_stb  (wr_stb),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr_lo (addr[CMD_AW-1:0]),
    .data_lo (data[7:0]),
    .wr_ok   (wr_ok),
    .at_k1   (at_k1),
    .at_k2   (at_k2),
    .cbyte   (cbyte)
  );

  sdp_prot_chk #(
    .AW         (AW),
    .PROT_WORDS (PROT_WORDS),
    .PROT_BASE  (PROT_BASE),
    .SEC_WORDS  (SEC_WORDS),
    .BLK_WORDS  (BLK_WORDS)
  ) u_prot (
    .addr   (addr),
    .span   (span),
    .wp_lat (wp_lat),
    .hit    (prot_hit)
  );

  sdp_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk        (clk),
    .rst_s      (rst_s),
    .wr_ok      (wr_ok),
    .at_k1      (at_k1),
    .at_k2      (at_k2),
    .cbyte      (cbyte),
    .addr       (addr),
    .data       (data),
    .wp_n       (wp_n),
    .prot_hit   (prot_hit),
    .span       (span),
    .wp_lat     (wp_lat),
    .prog_req   (prog_req),
    .erase_req  (erase_req),
    .erase_kind (erase_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .read_mode  (read_mode)
  );

  // R6: with protection latched on, nothing in the protected words is requested
  a_r6_no_prot_prog: assert property (@(posedge clk) disable iff (!rst_s)
    (prog_req && !$past(wp_lat)) |-> (op_addr < AW'(PROT_BASE)));

endmodule

// File: tb/sim_sdp_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdp_cmd_seq;

  logic        clk;
  logic        rst_n;
  logic        wr_stb;
  logic        ce_n;
  logic        we_n;
  logic        oe_n;
  logic [19:0] addr;
  logic [15:0] data;
  logic        wp_n;
  logic        prog_req;
  logic        erase_req;
  logic [1:0]  erase_kind;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  logic        read_mode;

  int n_chk;
  int n_err;

  sdp_cmd_seq u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .oe_n       (oe_n),
    .addr       (addr),
    .data       (data),
    .wp_n       (wp_n),
    .prog_req   (prog_req),
    .erase_req  (erase_req),
    .erase_kind (erase_kind),
    .op_addr    (op_addr),
    .op_data    (op_data),
    .read_mode  (read_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [19:0] a, input logic [15:0] d,
                        input logic c, input logic w, input logic o);
    @(negedge clk);
    addr = a; data = d; ce_n = c; we_n = w; oe_n = o; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [19:0] a, input logic [15:0] d);
    wr_raw(a, d, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic unlock3(input logic [7:0] cmd);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, {8'h00, cmd});
  endtask

  task automatic erase6(input logic [19:0] a, input logic [7:0] b);
    unlock3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(a, {8'h00, b});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk("R9 read_mode after reset", read_mode, 1);
    chk("R8 prog_req after reset", prog_req, 0);
    chk("R8 erase_req after reset", erase_req, 0);
  endtask

  task automatic t_program();
    unlock3(8'hA0);
    chk("R9 read_mode mid program", read_mode, 0);
    wr(20'h12345, 16'hC0DE);
    chk("R1 prog_req", prog_req, 1);
    chk("R1 op_addr", op_addr, 20'h12345);
    chk("R1 op_data", op_data, 16'hC0DE);
    chk("R10 no erase with program", erase_req, 0);
    chk("R9 read_mode after program", read_mode, 1);
    @(negedge clk);
    chk("R10 prog pulse one cycle", prog_req, 0);
  endtask

  task automatic t_erase_kinds();
    erase6(20'h23456, 8'h30);
    chk("R2 sector erase_req", erase_req, 1);
    chk("R2 sector kind", erase_kind, 0);
    chk("R2 sector addr", op_addr, 20'h23456);
    chk("R10 no prog with erase", prog_req, 0);
    @(negedge clk);
    chk("R10 erase pulse one cycle", erase_req, 0);
    erase6(20'h48000, 8'h50);
    chk("R2 block erase_req", erase_req, 1);
    chk("R2 block kind", erase_kind, 1);
    chk("R2 block addr", op_addr, 20'h48000);
    erase6(20'h05555, 8'h10);
    chk("R2 chip erase_req", erase_req, 1);
    chk("R2 chip kind", erase_kind, 2);
  endtask

  task automatic t_abort();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h0077);
    chk("R3 read_mode after bad command", read_mode, 1);
    wr(20'h01000, 16'h1111);
    chk("R3 no program after abort", prog_req, 0);
    unlock3(8'h80);
    wr(20'h05555, 16'h00AA);
    wr(20'h05555, 16'h0055);
    chk("R3 read_mode after bad erase address", read_mode, 1);
    wr(20'h03000, 16'h0030);
    chk("R3 no erase after abort", erase_req, 0);
    erase6(20'h01234, 8'h10);
    chk("R3 chip byte off key address", erase_req, 0);
    chk("R3 read_mode after bad final", read_mode, 1);
  endtask

  task automatic t_upper_byte();
    wr(20'hF5555, 16'hFFAA);
    wr(20'h32AAA, 16'h3C55);
    wr(20'h05555, 16'h12A0);
    wr(20'h00400, 16'hBEEF);
    chk("R4 program with upper bytes set", prog_req, 1);
    chk("R4 target data kept whole", op_data, 16'hBEEF);
    unlock3(8'h80);
    wr(20'h05555, 16'h55AA);
    wr(20'h02AAA, 16'hAA55);
    wr(20'h06000, 16'h7730);
    chk("R4 sector erase with upper byte", erase_req, 1);
    chk("R4 sector kind with upper byte", erase_kind, 0);
  endtask

  task automatic t_inhibit();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
    wr_raw(20'h05555, 16'h0077, 1'b1, 1'b0, 1'b1);
    chk("R5 ce_n high ignored", read_mode, 0);
    wr_raw(20'h05555, 16'h0077, 1'b0, 1'b1, 1'b1);
    chk("R5 we_n high ignored", read_mode, 0);
    wr_raw(20'h05555, 16'h0077, 1'b0, 1'b0, 1'b0);
    chk("R5 oe_n low ignored", read_mode, 0);
    wr(20'h05555, 16'h00A0);
    wr_raw(20'h07000, 16'h2222, 1'b0, 1'b0, 1'b0);
    chk("R5 inhibited target no request", prog_req, 0);
    chk("R5 still waiting for target", read_mode, 0);
    wr(20'h07000, 16'h3333);
    chk("R5 program after inhibited cycles", prog_req, 1);
    chk("R5 program data", op_data, 16'h3333);
  endtask

  task automatic t_protect();
    wp_n = 1'b0;
    unlock3(8'hA0); wr(20'hFF000, 16'h4444);
    chk("R6 program in protected words", prog_req, 0);
    chk("R6 read_mode after suppressed", read_mode, 1);
    unlock3(8'hA0); wr(20'h10000, 16'h4444);
    chk("R6 program outside protected words", prog_req, 1);
    erase6(20'hF8000, 8'h50);
    chk("R6 block overlapping protected", erase_req, 0);
    erase6(20'hFD800, 8'h30);
    chk("R6 sector just below protected", erase_req, 1);
    erase6(20'hFE800, 8'h30);
    chk("R6 sector inside protected", erase_req, 0);
    erase6(20'h05555, 8'h10);
    chk("R6 chip erase while protected", erase_req, 0);
    wp_n = 1'b1;
    unlock3(8'hA0); wr(20'hFF000, 16'h5555);
    chk("R6 program unprotected", prog_req, 1);
    erase6(20'h05555, 8'h10);
    chk("R6 chip erase unprotected", erase_req, 1);
  endtask

  task automatic t_wp_latch();
    wp_n = 1'b0;
    wr(20'h05555, 16'h00AA);
    wp_n = 1'b1;
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'hFF100, 16'h6666);
    chk("R7 low latch holds protection", prog_req, 0);
    wp_n = 1'b1;
    wr(20'h05555, 16'h00AA);
    wp_n = 1'b0;
    wr(20'h02AAA, 16'h0055);
    wr(20'h05555, 16'h00A0);
    wr(20'hFF100, 16'h7777);
    chk("R7 high latch keeps access", prog_req, 1);
    wp_n = 1'b1;
  endtask

  task automatic t_hw_reset();
    unlock3(8'hA0);
    chk("R9 mid sequence before reset", read_mode, 0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 read_mode while in reset", read_mode, 1);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 read_mode after release", read_mode, 1);
    wr(20'h08000, 16'h8888);
    chk("R8 interrupted program not resumed", prog_req, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    wr_stb = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    addr = '0; data = '0; wp_n = 1'b1;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_program();
    t_erase_kinds();
    t_abort();
    t_upper_byte();
    t_inhibit();
    t_protect();
    t_wp_latch();
    t_hw_reset();
    do_reset();
    t_reset_state();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule